// File: doc/BRIEF.md
# Gain-Ranged Sample Normalizer with Channel Demux

This block sits behind a gain-ranging converter. The converter delivers each sample as a short two's complement mantissa, a gain-range exponent and a channel flag. The block turns each accepted sample into a 16-bit two's complement fixed-point word. To do this it left-justifies the mantissa and then shifts it arithmetically right by the distance the exponent calls for. The result goes out on the channel A stream or the channel B stream, and each stream has its own valid strobe.

A two-bit mode input selects dual-channel operation, single A, single B, or an invalid setting. In dual-channel mode the flag steers each sample, and the two channels are expected to alternate. In a single-channel mode the flag is ignored. Two sticky flags report problems: an exponent code above the legal range, and a dual-mode sample that repeats the channel of the sample before it. Both flags stay set until they are cleared.

Top module: `gnd_norm_demux`

## Requirements
- R1: An accepted sample with mantissa m (11-bit two's complement) and exponent e in 0..5 produces the word {m, 5'b00000} shifted right arithmetically by 5 - e, with the sign bit copied into the vacated bits.
- R2: Exponent 5 gives the mantissa a weight of 32, with no shift. Exponent 0 gives a weight of 1: a shift of 5, so that mantissa -1024 yields 16'hFC00 and mantissa 1 yields 16'h0001.
- R3: Exponent codes 6 and 7 are out of range. Such a sample is normalized with a shift of zero, and range_err_o goes to 1 on the following cycle and stays at 1 until it is cleared.
- R4: The latency is exactly one cycle. An accepted sample on an input edge drives exactly one of a_valid_o or b_valid_o high for the next cycle only, with its word on that channel's data output.
- R5: With mode_i = 2'b11 (dual), chan_a_i = 1 sends the sample to channel A and chan_a_i = 0 sends it to channel B.
- R6: With mode_i = 2'b10 every sample goes to channel A, and with mode_i = 2'b01 every sample goes to channel B, whatever chan_a_i is.
- R7: With mode_i = 2'b00 (invalid), samples are dropped. No valid strobe is raised and neither error flag is set.
- R8: In dual mode, an accepted sample whose flag equals the flag of the previous accepted dual-mode sample sets seq_err_o on the next cycle. The flag then stays set until it is cleared. Idle cycles do not break the pairing. Any cycle in which the mode is not dual discards the history.
- R9: err_clr_i clears both sticky flags on the next edge. A new error detected on the same edge wins over the clear.
- R10: While rst_ni is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 11 dual, 10 single A, 01 single B, 00 invalid |
| in_valid_i | input | 1 | Sample strobe |
| mant_i | input | 11 | Mantissa, two's complement |
| exp_i | input | 3 | Gain-range exponent, offset binary |
| chan_a_i | input | 1 | Channel flag: 1 = A, 0 = B |
| err_clr_i | input | 1 | Clears both sticky error flags |
| a_valid_o | output | 1 | Channel A word strobe |
| a_data_o | output | 16 | Channel A fixed-point word |
| b_valid_o | output | 1 | Channel B word strobe |
| b_data_o | output | 16 | Channel B fixed-point word |
| range_err_o | output | 1 | Sticky: out-of-range exponent seen |
| seq_err_o | output | 1 | Sticky: channel alternation broken |

## Verification
The bench aims at the extreme shift amounts: the most negative mantissa at exponent 0, which a logical shift would turn into a large positive number, and exponent 5, where an off-by-one shift would halve or double the word. It drives exponents 6 and 7, which a design without saturation would wrap into huge shifts, and it checks that the flag set on those samples survives idle cycles. It repeats channel flags across idle gaps and across mode switches, so a design that resets the pairing on idle cycles, or one that keeps stale history, will flag the wrong samples. It also drives the flag against the selected channel in single mode, and raises a clear on the same edge as a new error, which a design with the wrong priority would lose.

// File: rtl/gnd_pkg.sv
package gnd_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_B    = 2'b01,
    MODE_A    = 2'b10,
    MODE_DUAL = 2'b11
  } gnd_mode_e;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_A   = 0;
  localparam int unsigned CH_B   = 1;
endpackage

// File: rtl/gnd_shift.sv
module gnd_shift #(
  parameter int unsigned MANT_W  = 11,
  parameter int unsigned EXP_W   = 3,
  parameter int unsigned OUT_W   = 16,
  parameter int unsigned EXP_MAX = 5
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic [OUT_W-1:0]  data_o,
  output logic              range_bad_o
);
  localparam int unsigned PAD = OUT_W - MANT_W;

  logic [EXP_W-1:0]        shamt;
  logic signed [OUT_W-1:0] justified;

  always_comb begin
    range_bad_o = exp_i > EXP_W'(EXP_MAX);
    // offset-binary code: shift is distance from the top code
    shamt       = range_bad_o ? '0 : EXP_W'(EXP_MAX) - exp_i;
    justified   = $signed({mant_i, {PAD{1'b0}}});
    data_o      = justified >>> shamt;
  end
endmodule

// File: rtl/gnd_route.sv
module gnd_route
  import gnd_pkg::*;
(
  input  logic      valid_i,
  input  gnd_mode_e mode_i,
  input  logic      chan_a_i,
  output logic      accept_o,
  output logic      dual_o,
  output logic      to_a_o,
  output logic      to_b_o
);
  always_comb begin
    dual_o   = mode_i == MODE_DUAL;
    accept_o = valid_i && (mode_i != MODE_OFF);
    unique case (mode_i)
      MODE_DUAL: to_a_o = accept_o && chan_a_i;
      MODE_A:    to_a_o = accept_o;
      default:   to_a_o = 1'b0;
    endcase
    to_b_o = accept_o && !to_a_o;
  end
endmodule

// File: rtl/gnd_flags.sv
module gnd_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic dual_i,
  input  logic chan_a_i,
  input  logic range_bad_i,
  input  logic clr_i,
  output logic range_err_o,
  output logic seq_err_o
);
  logic have_last_q, last_a_q;
  logic seq_hit, range_hit;

  assign seq_hit   = accept_i && dual_i && have_last_q && (last_a_q == chan_a_i);
  assign range_hit = accept_i && range_bad_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_last_q <= 1'b0;
      last_a_q    <= 1'b0;
      range_err_o <= 1'b0;
      seq_err_o   <= 1'b0;
    end else begin
      if (!dual_i) begin
        have_last_q <= 1'b0;
      end else if (accept_i) begin
        have_last_q <= 1'b1;
        last_a_q    <= chan_a_i;
      end
      // new error wins over clear
      range_err_o <= range_hit | (range_err_o & ~clr_i);
      seq_err_o   <= seq_hit   | (seq_err_o   & ~clr_i);
    end
  end
endmodule

// File: rtl/gnd_norm_demux.sv
module gnd_norm_demux
  import gnd_pkg::*;
#(
  parameter int unsigned MANT_W  = 11,
  parameter int unsigned EXP_W   = 3,
  parameter int unsigned OUT_W   = 16,
  parameter int unsigned EXP_MAX = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              in_valid_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic              chan_a_i,
  input  logic              err_clr_i,
  output logic              a_valid_o,
  output logic [OUT_W-1:0]  a_data_o,
  output logic              b_valid_o,
  output logic [OUT_W-1:0]  b_data_o,
  output logic              range_err_o,
  output logic              seq_err_o
);
  logic [OUT_W-1:0] norm_data;
  logic             range_bad, accept, dual;
  logic [NUM_CH-1:0] ch_sel, ch_vld_q;
  logic [OUT_W-1:0]  ch_dat_q [NUM_CH];

  gnd_shift #(
    .MANT_W (MANT_W),
    .EXP_W  (EXP_W),
    .OUT_W  (OUT_W),
    .EXP_MAX(EXP_MAX)
  ) i_shift (
    .mant_i     (mant_i),
    .exp_i      (exp_i),
    .data_o     (norm_data),
    .range_bad_o(range_bad)
  );

  gnd_route i_route (
    .valid_i (in_valid_i),
    .mode_i  (gnd_mode_e'(mode_i)),
    .chan_a_i(chan_a_i),
    .accept_o(accept),
    .dual_o  (dual),
    .to_a_o  (ch_sel[CH_A]),
    .to_b_o  (ch_sel[CH_B])
  );

  gnd_flags i_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .dual_i     (dual),
    .chan_a_i   (chan_a_i),
    .range_bad_i(range_bad),
    .clr_i      (err_clr_i),
    .range_err_o(range_err_o),
    .seq_err_o  (seq_err_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ch_vld_q[c] <= 1'b0;
        ch_dat_q[c] <= '0;
      end else begin
        ch_vld_q[c] <= ch_sel[c];
        if (ch_sel[c]) ch_dat_q[c] <= norm_data;
      end
    end
  end

  assign a_valid_o = ch_vld_q[CH_A];
  assign a_data_o  = ch_dat_q[CH_A];
  assign b_valid_o = ch_vld_q[CH_B];
  assign b_data_o  = ch_dat_q[CH_B];
endmodule

// File: rtl/gnd_norm_demux_chk.sv
module gnd_norm_demux_chk #(
  parameter int unsigned MANT_W  = 11,
  parameter int unsigned EXP_W   = 3,
  parameter int unsigned OUT_W   = 16,
  parameter int unsigned EXP_MAX = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              in_valid_i,
  input logic [MANT_W-1:0] mant_i,
  input logic [EXP_W-1:0]  exp_i,
  input logic              chan_a_i,
  input logic              err_clr_i,
  input logic              a_valid_o,
  input logic [OUT_W-1:0]  a_data_o,
  input logic              b_valid_o,
  input logic [OUT_W-1:0]  b_data_o,
  input logic              range_err_o,
  input logic              seq_err_o
);
  localparam int unsigned PAD = OUT_W - MANT_W;

  p_top_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && mode_i == 2'b11 && chan_a_i && exp_i == EXP_W'(EXP_MAX)
    |=> a_valid_o && a_data_o == {$past(mant_i), {PAD{1'b0}}});

  p_range_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && mode_i != 2'b00 && exp_i > EXP_W'(EXP_MAX) |=> range_err_o);

  p_one_hot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({a_valid_o, b_valid_o}));

  p_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !a_valid_o && !b_valid_o);

  p_dual_b_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && mode_i == 2'b11 && !chan_a_i |=> b_valid_o);

  p_single_a_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && mode_i == 2'b10 |=> a_valid_o);

  p_single_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && mode_i == 2'b01 |=> b_valid_o);

  p_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b00 |=> !a_valid_o && !b_valid_o);

  p_sticky_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_err_o && !err_clr_i |=> range_err_o);

  p_sticky_seq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o && !err_clr_i |=> seq_err_o);

  always_comb begin
    if (!rst_ni) begin
      a_reset_r10: assert (!a_valid_o && !b_valid_o && !range_err_o && !seq_err_o);
    end
  end
endmodule

bind gnd_norm_demux gnd_norm_demux_chk #(
  .MANT_W (MANT_W),
  .EXP_W  (EXP_W),
  .OUT_W  (OUT_W),
  .EXP_MAX(EXP_MAX)
) i_chk (.*);

// File: tb/test_gnd_norm_demux.sv
module test_gnd_norm_demux;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        in_valid_i = 1'b0;
  logic [10:0] mant_i = '0;
  logic [2:0]  exp_i = '0;
  logic        chan_a_i = 1'b0;
  logic        err_clr_i = 1'b0;
  logic        a_valid_o, b_valid_o, range_err_o, seq_err_o;
  logic [15:0] a_data_o, b_data_o;

  int checks = 0;
  int fails  = 0;
  logic m_rng = 0, m_seq = 0, m_hl = 0, m_la = 0;

  always #4 clk_i = ~clk_i;

  gnd_norm_demux i_gnd_norm_demux (.*);

  function automatic logic [15:0] norm(input logic [10:0] m, input logic [2:0] e);
    logic signed [15:0] w;
    int sh;
    w  = {m, 5'b0};
    sh = (e > 3'd5) ? 0 : 5 - int'(e);
    return 16'(w >>> sh);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, check at following negedge (one posedge between)
  task automatic step(input logic v, input logic [1:0] m, input logic [10:0] mt,
                      input logic [2:0] e, input logic ca, input logic clr);
    logic acc, toa, tob, dual, shit, rhit;
    logic [15:0] w;
    in_valid_i = v; mode_i = m; mant_i = mt; exp_i = e; chan_a_i = ca; err_clr_i = clr;
    acc  = v && (m != 2'b00);
    toa  = acc && ((m == 2'b11) ? ca : (m == 2'b10));
    tob  = acc && !toa;
    dual = (m == 2'b11);
    shit = acc && dual && m_hl && (m_la == ca);
    rhit = acc && (e > 3'd5);
    if (!dual) m_hl = 0;
    else if (acc) begin m_hl = 1; m_la = ca; end
    m_seq = shit | (m_seq & !clr);
    m_rng = rhit | (m_rng & !clr);
    w = norm(mt, e);
    @(negedge clk_i);
    check("R4/R5/R6/R7 a_valid", 16'(a_valid_o), 16'(toa));
    check("R4/R5/R6/R7 b_valid", 16'(b_valid_o), 16'(tob));
    if (toa) check("R1/R2 a_data", a_data_o, w);
    if (tob) check("R1/R2 b_data", b_data_o, w);
    check("R3/R9 range_err", 16'(range_err_o), 16'(m_rng));
    check("R8/R9 seq_err", 16'(seq_err_o), 16'(m_seq));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    in_valid_i = 1'b1; mode_i = 2'b11; chan_a_i = 1'b1;
    repeat (2) @(negedge clk_i);
    // R10 reset state
    check("R10 reset outputs", {a_valid_o, b_valid_o, range_err_o, seq_err_o, 12'h0}, 16'h0);
    check("R10 reset a_data", a_data_o, 16'h0);
    in_valid_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    // R2 extremes
    step(1, 2'b11, 11'h400, 3'd0, 1, 0);
    check("R2 -1024 exp0", a_data_o, 16'hFC00);
    step(1, 2'b11, 11'h001, 3'd0, 0, 0);
    check("R2 1 exp0", b_data_o, 16'h0001);
    step(1, 2'b11, 11'h3FF, 3'd5, 1, 0);
    check("R2 max exp5", a_data_o, 16'h7FE0);
    step(1, 2'b11, 11'h7FF, 3'd3, 0, 0);   // R1 -1 stays -1 style sign fill
    check("R1 -1 exp3", b_data_o, 16'hFFF8);
    // R3 out-of-range codes, sticky through idle
    step(1, 2'b11, 11'h155, 3'd6, 1, 0);
    step(0, 2'b11, 11'h000, 3'd0, 0, 0);
    step(1, 2'b11, 11'h2AA, 3'd7, 0, 0);
    step(0, 2'b11, 11'h000, 3'd0, 0, 1);
    // R8 repeat across idle gap, then clear racing new error (R9)
    step(1, 2'b11, 11'h010, 3'd2, 1, 0);
    step(0, 2'b11, 11'h000, 3'd0, 1, 0);
    step(1, 2'b11, 11'h020, 3'd2, 1, 0);
    step(1, 2'b11, 11'h030, 3'd2, 1, 1);
    step(1, 2'b11, 11'h040, 3'd2, 0, 1);
    // R8 history dropped by mode change; R6 flag ignored
    step(1, 2'b10, 11'h050, 3'd4, 0, 0);
    step(1, 2'b11, 11'h060, 3'd4, 0, 0);
    step(1, 2'b01, 11'h070, 3'd1, 1, 0);
    // R7 invalid mode with bad exponent
    step(1, 2'b00, 11'h080, 3'd7, 1, 1);
    step(1, 2'b00, 11'h090, 3'd6, 0, 0);
    // random
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] m;
      logic [2:0] e;
      m = ($urandom % 4 == 0) ? 2'($urandom) : 2'b11;
      e = ($urandom % 8 == 0) ? 3'($urandom) : 3'($urandom % 6);
      step(($urandom % 4) != 0, m, 11'($urandom), e, 1'($urandom), ($urandom % 16) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule